// File: doc/BRIEF.md
# Legacy Interrupt Line Aggregator

This block sits on the downstream side of a switch port and merges the legacy level-style interrupt messages that arrive from the devices and ports below it. It keeps four interrupt lines, A through D. For each line it holds a small table of the source IDs that currently hold that line asserted.

Only changes to a line's collective state are sent upstream. The first source to assert an idle line produces one upstream assert pulse. The last source to release the line produces one upstream deassert pulse. Repeated or intermediate messages produce nothing upstream.

Messages arrive one per clock on a single strobe carrying a message code and a source ID, so arrival order is always well defined. A readable pending vector shows which lines are currently held toward the upstream side.

Top module: `intx_collector`

## Requirements
- R1: Codes 0x20..0x23 assert lines A..D, where line index = code - 0x20 and bit 0 is line A. An assert on a line whose table is empty pulses that line's bit of `up_assert` for exactly one cycle, in the cycle after the message is taken.
- R2: An assert from a source already recorded on that line changes nothing and sends nothing upstream. The source stays as a single entry, so one deassert from it empties that entry.
- R3: `pending[l]` is high exactly when line l holds at least one recorded source. It changes on the same edge as the matching upstream pulse.
- R4: Codes 0x24..0x27 deassert lines A..D. A deassert removes only the named source. `up_deassert[l]` pulses for one cycle only when that removal leaves the line's table empty.
- R5: A deassert naming a source that is not recorded on that line is ignored: no upstream pulse and no change to `pending`.
- R6: A strobed message with any code outside 0x20..0x27 pulses `code_err` for one cycle and changes no line state.
- R7: Each line records at most SLOTS sources (default 8). An assert from a new source on a full line pulses `overflow` for one cycle and leaves the table unchanged.
- R8: Messages are handled strictly one per cycle, in arrival order. An assert followed on the next cycle by a deassert for the same line and source gives an assert pulse, then a deassert pulse, and ends not pending. The reverse order ends pending.
- R9: After reset, `pending`, `up_assert`, `up_deassert`, `code_err` and `overflow` are all zero.
- R10: While `msg_vld` is low, the code and source inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_vld | input | 1 | Message strobe, one message per cycle |
| msg_code | input | 8 | Message code |
| msg_src | input | SRC_W | Source ID of the sender |
| up_assert | output | 4 | One-cycle upstream assert pulse per line |
| up_deassert | output | 4 | One-cycle upstream deassert pulse per line |
| pending | output | 4 | Lines currently held toward upstream |
| code_err | output | 1 | Pulse: strobed code not an interrupt message |
| overflow | output | 1 | Pulse: new source refused on a full line |

## Verification
The bench targets duplicate asserts: a design that stored a source twice would stay pending after that source's single deassert. It also sends deasserts from sources that never asserted; a design that failed to ignore them would drop the line early or emit a stray deassert. Lines are filled to capacity and then offered a ninth source and a repeat of an existing one, which separates a correct full check from an off-by-one that refuses duplicates or overwrites a slot. Back-to-back assert and deassert pairs expose any design that reorders or merges messages. Codes just outside both ranges expose a wrong range decode.

// File: rtl/intx_collector.sv
module intx_collector #(
  parameter int          SRC_W   = 16,
  parameter int          SLOTS   = 8,
  parameter logic [7:0]  AS_BASE = 8'h20,
  parameter logic [7:0]  DS_BASE = 8'h24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_vld,
  input  logic [7:0]       msg_code,
  input  logic [SRC_W-1:0] msg_src,
  output logic [3:0]       up_assert,
  output logic [3:0]       up_deassert,
  output logic [3:0]       pending,
  output logic             code_err,
  output logic             overflow
);
  localparam int LINES = 4;

  logic [7:0] as_off, ds_off;
  logic       is_as, is_ds;
  assign as_off = msg_code - AS_BASE;
  assign ds_off = msg_code - DS_BASE;
  assign is_as  = msg_vld && (as_off < 8'(LINES));
  assign is_ds  = msg_vld && (ds_off < 8'(LINES));

  logic [LINES-1:0] rise, fall, refuse;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [SLOTS-1:0] vld_q, hit, free_1h;
    logic [SRC_W-1:0] ids_q [SLOTS];
    logic             sel_as, sel_ds, take;

    assign sel_as  = is_as && (as_off[1:0] == 2'(l));
    assign sel_ds  = is_ds && (ds_off[1:0] == 2'(l));
    assign free_1h = ~vld_q & (vld_q + 1'b1);
    assign take    = sel_as && (hit == '0) && !(&vld_q);

    always_comb
      for (int s = 0; s < SLOTS; s++)
        hit[s] = vld_q[s] && (ids_q[s] == msg_src);

    always_ff @(posedge clk) begin
      if (!rst_n)      vld_q <= '0;
      else if (take)   vld_q <= vld_q | free_1h;
      else if (sel_ds) vld_q <= vld_q & ~hit;
    end

    always_ff @(posedge clk)
      for (int s = 0; s < SLOTS; s++)
        if (take && free_1h[s]) ids_q[s] <= msg_src;

    assign rise[l]    = take && (vld_q == '0);
    assign fall[l]    = sel_ds && (hit != '0) && ((vld_q & ~hit) == '0);
    assign refuse[l]  = sel_as && (hit == '0) && (&vld_q);
    assign pending[l] = |vld_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_assert   <= '0;
      up_deassert <= '0;
      code_err    <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      up_assert   <= rise;
      up_deassert <= fall;
      code_err    <= msg_vld && !is_as && !is_ds;
      overflow    <= |refuse;
    end
  end

  AST_RISE_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~$past(pending)) == up_assert); // R1
  AST_FALL_DEASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) & ~pending) == up_deassert); // R4
  AST_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (up_assert & up_deassert) == 4'b0); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> $stable(pending) && up_assert == 4'b0 && !overflow); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $stable(pending) && up_assert == 4'b0); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(msg_vld) |-> $stable(pending) && !code_err && !overflow); // R10
endmodule

// File: tb/intx_collector_bench.sv
`timescale 1ns/1ps
module intx_collector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_vld = 1'b0;
  logic [7:0]  msg_code = '0;
  logic [15:0] msg_src = '0;
  logic [3:0]  up_assert, up_deassert, pending;
  logic        code_err, overflow;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intx_collector u_intx_collector (
    .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_code(msg_code),
    .msg_src(msg_src), .up_assert(up_assert), .up_deassert(up_deassert),
    .pending(pending), .code_err(code_err), .overflow(overflow));

  // code, src, up_assert, up_deassert, pending, code_err
  localparam int NV = 17;
  localparam logic [36:0] VEC [NV] = '{
    {8'h20, 16'd5, 4'b0001, 4'b0000, 4'b0001, 1'b0},
    {8'h20, 16'd5, 4'b0000, 4'b0000, 4'b0001, 1'b0},
    {8'h20, 16'd9, 4'b0000, 4'b0000, 4'b0001, 1'b0},
    {8'h24, 16'd5, 4'b0000, 4'b0000, 4'b0001, 1'b0},
    {8'h24, 16'd5, 4'b0000, 4'b0000, 4'b0001, 1'b0},
    {8'h24, 16'd7, 4'b0000, 4'b0000, 4'b0001, 1'b0},
    {8'h24, 16'd9, 4'b0000, 4'b0001, 4'b0000, 1'b0},
    {8'h22, 16'd3, 4'b0100, 4'b0000, 4'b0100, 1'b0},
    {8'h23, 16'd3, 4'b1000, 4'b0000, 4'b1100, 1'b0},
    {8'h30, 16'd1, 4'b0000, 4'b0000, 4'b1100, 1'b1},
    {8'h26, 16'd3, 4'b0000, 4'b0100, 4'b1000, 1'b0},
    {8'h25, 16'd3, 4'b0000, 4'b0000, 4'b1000, 1'b0},
    {8'h21, 16'd2, 4'b0010, 4'b0000, 4'b1010, 1'b0},
    {8'h25, 16'd2, 4'b0000, 4'b0010, 4'b1000, 1'b0},
    {8'h27, 16'd3, 4'b0000, 4'b1000, 4'b0000, 1'b0},
    {8'h1F, 16'd3, 4'b0000, 4'b0000, 4'b0000, 1'b1},
    {8'h28, 16'd3, 4'b0000, 4'b0000, 4'b0000, 1'b1}
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic vld, logic [7:0] code, logic [15:0] src);
    msg_vld = vld; msg_code = code; msg_src = src;
    @(negedge clk);
    msg_vld = 1'b0;
  endtask

  task automatic expect_out(string req, logic [3:0] ea, logic [3:0] ed,
                            logic [3:0] ep, logic ee, logic eo);
    chk(req, "up_assert", int'(up_assert), int'(ea));
    chk(req, "up_deassert", int'(up_deassert), int'(ed));
    chk(req, "pending", int'(pending), int'(ep));
    chk(req, "code_err", int'(code_err), int'(ee));
    chk(req, "overflow", int'(overflow), int'(eo));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R9", 4'b0, 4'b0, 4'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R9", 4'b0, 4'b0, 4'b0, 1'b0, 1'b0);

    // table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      send(1'b1, VEC[i][36:29], VEC[i][28:13]);
      expect_out($sformatf("R1-6 vec%0d", i), VEC[i][12:9], VEC[i][8:5],
                 VEC[i][4:1], VEC[i][0], 1'b0);
    end

    // R10: strobe low, assert code present
    send(1'b0, 8'h20, 16'd44);
    expect_out("R10", 4'b0, 4'b0, 4'b0, 1'b0, 1'b0);

    // R7: fill line B
    for (int s = 0; s < 8; s++) begin
      send(1'b1, 8'h21, 16'(10 + s));
      expect_out("R7 fill", (s == 0) ? 4'b0010 : 4'b0, 4'b0, 4'b0010, 1'b0, 1'b0);
    end
    send(1'b1, 8'h21, 16'd30);
    expect_out("R7 full", 4'b0, 4'b0, 4'b0010, 1'b0, 1'b1);
    send(1'b1, 8'h21, 16'd12);
    expect_out("R2 dup on full", 4'b0, 4'b0, 4'b0010, 1'b0, 1'b0);
    send(1'b1, 8'h25, 16'd30);
    expect_out("R5 refused src", 4'b0, 4'b0, 4'b0010, 1'b0, 1'b0);
    for (int s = 0; s < 8; s++) begin
      send(1'b1, 8'h25, 16'(10 + s));
      expect_out("R4 drain", 4'b0, (s == 7) ? 4'b0010 : 4'b0,
                 (s == 7) ? 4'b0 : 4'b0010, 1'b0, 1'b0);
    end

    // R8: back-to-back ordering
    send(1'b1, 8'h20, 16'd1);
    expect_out("R8 as", 4'b0001, 4'b0, 4'b0001, 1'b0, 1'b0);
    send(1'b1, 8'h24, 16'd1);
    expect_out("R8 ds", 4'b0, 4'b0001, 4'b0, 1'b0, 1'b0);
    send(1'b1, 8'h27, 16'd6);
    expect_out("R8 early ds", 4'b0, 4'b0, 4'b0, 1'b0, 1'b0);
    send(1'b1, 8'h23, 16'd6);
    expect_out("R8 late as", 4'b1000, 4'b0, 4'b1000, 1'b0, 1'b0);

    // R9: reset clears held line
    rst_n = 1'b0;
    @(negedge clk);
    expect_out("R9 mid", 4'b0, 4'b0, 4'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule